// File: doc/BRIEF.md
# Fetch-to-Execute Instruction Queue

This block is a short queue placed between an instruction fetch stage and an execute stage. Every entry holds three fields: the instruction word, the address it was fetched from, and the next address that fetch predicted. The producer side is a valid/ready pair, and so is the consumer side. A flush input lets the execute stage drop every queued entry when a prediction turns out to be wrong.

Push, pop and flush can all be requested in the same clock cycle. Flush is treated as if it happens after the push. An entry written in a flushing cycle is therefore lost along with the older ones, and the consumer is never shown a wrong-path entry. Both handshake readies come only from the occupancy registered at the start of the cycle. No input feeds combinationally through to the opposite side, and with two slots the producer and consumer can still overlap at one entry per cycle. Depth and field widths are parameters. Storage is a circular buffer with separate read and write pointers.

Top module: `fetch_exec_queue`

## Requirements
- R1: Entries leave in the order they were accepted. Each one presents its instruction, fetch address and predicted address unchanged on `deq_instr`, `deq_pc` and `deq_ppc`.
- R2: While the synchronous active-high `rst` is sampled high at a clock edge, the queue becomes empty. After that edge `deq_valid` is 0 and `enq_ready` is 1.
- R3: `enq_ready` is 0 exactly when the queue held DEPTH entries at the start of the cycle. A push offered while full is not accepted, even if a pop happens in that same cycle.
- R4: `deq_valid` is 1 exactly when the queue held at least one entry at the start of the cycle.
- R5: After a cycle with `flush` high, the queue is empty (`deq_valid` 0, `enq_ready` 1). This holds whatever push or pop was requested in that cycle. Flush overrides a same-cycle pop.
- R6: An entry pushed in the same cycle as `flush` is discarded. The next entry presented is the first one pushed after the flush.
- R7: A push and a pop in the same cycle on a queue that is neither empty nor full both take effect. With the default depth of 2, a stream sustains one entry per cycle.
- R8: While `deq_valid` is 1, `deq_ready` is 0 and no flush occurs, the presented entry's three fields stay unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Drop all entries, including one pushed this cycle |
| enq_valid | input | 1 | Producer offers an entry |
| enq_ready | output | 1 | Queue can accept an entry this cycle |
| enq_instr | input | IW | Instruction word of offered entry |
| enq_pc | input | AW | Fetch address of offered entry |
| enq_ppc | input | AW | Predicted next address of offered entry |
| deq_valid | output | 1 | An entry is presented |
| deq_ready | input | 1 | Consumer takes the presented entry |
| deq_instr | output | IW | Instruction word of oldest entry |
| deq_pc | output | AW | Fetch address of oldest entry |
| deq_ppc | output | AW | Predicted next address of oldest entry |

## Verification
The bench aims at cycles where flush coincides with a push or a pop. If flush were applied before the push, a stale wrong-path entry would reach the consumer. If pop won over flush, a pointer would be left off zero and later entries would come out of order. It also offers a push to a full queue while popping. A design that derived `enq_ready` from the pop would accept that entry, which breaks R3. Long mixed traffic wraps the pointers many times, so a wrap error shows up as reordered or corrupted fields, and stalled outputs are compared against the previous cycle's entry.

// File: rtl/fetch_exec_queue.sv
module fetch_exec_queue #(
  parameter int DEPTH = 2,
  parameter int IW    = 32,
  parameter int AW    = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          enq_valid,
  output logic          enq_ready,
  input  logic [IW-1:0] enq_instr,
  input  logic [AW-1:0] enq_pc,
  input  logic [AW-1:0] enq_ppc,
  output logic          deq_valid,
  input  logic          deq_ready,
  output logic [IW-1:0] deq_instr,
  output logic [AW-1:0] deq_pc,
  output logic [AW-1:0] deq_ppc
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = IW + 2 * AW;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [EW-1:0] slots [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;
  logic enq_fire, deq_fire;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign enq_ready = (count != FULL);
  assign deq_valid = (count != '0);
  assign enq_fire  = enq_valid && enq_ready;
  assign deq_fire  = deq_valid && deq_ready;
  assign {deq_instr, deq_pc, deq_ppc} = slots[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (enq_fire) wr_ptr <= bump(wr_ptr);
      if (deq_fire) rd_ptr <= bump(rd_ptr);
      count <= count + CW'(enq_fire) - CW'(deq_fire);
    end
  end

  always_ff @(posedge clk) begin
    if (enq_fire) slots[wr_ptr] <= {enq_instr, enq_pc, enq_ppc};
  end

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!deq_valid && enq_ready)); // R5

  AST_FLUSH_KILLS_PUSH: assert property (@(posedge clk) disable iff (rst)
    (flush && enq_valid && enq_ready) |=> !deq_valid); // R6

  AST_PUSH_SHOWS: assert property (@(posedge clk) disable iff (rst)
    (enq_valid && enq_ready && !flush) |=> deq_valid); // R4

  AST_FULL_STAYS: assert property (@(posedge clk) disable iff (rst)
    (!enq_ready && !(deq_valid && deq_ready) && !flush) |=> !enq_ready); // R3

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (deq_valid && !deq_ready && !flush) |=>
      (deq_valid && $stable(deq_instr) && $stable(deq_pc) && $stable(deq_ppc))); // R8

  AST_OVERLAP_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (enq_valid && enq_ready && deq_valid && deq_ready && !flush) |=> deq_valid); // R7
endmodule

// File: tb/fetch_exec_queue_test.sv
module fetch_exec_queue_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 2;
  localparam int NV = 32;
  // bits: {enq_valid, deq_ready, flush}
  localparam logic [2:0] VEC [NV] = '{
    3'b100, 3'b100, 3'b100, 3'b010, 3'b110, 3'b110, 3'b110, 3'b110,
    3'b101, 3'b010, 3'b100, 3'b100, 3'b110, 3'b011, 3'b000, 3'b100,
    3'b000, 3'b010, 3'b010, 3'b111, 3'b100, 3'b110, 3'b001, 3'b110,
    3'b100, 3'b100, 3'b000, 3'b010, 3'b110, 3'b010, 3'b010, 3'b000};

  logic clk = 0, rst = 1, flush = 0, enq_valid = 0, deq_ready = 0;
  logic enq_ready, deq_valid;
  logic [31:0] enq_instr = 0, enq_pc = 0, enq_ppc = 0;
  logic [31:0] deq_instr, deq_pc, deq_ppc;

  int checks = 0, misses = 0, cyc = 0;
  int unsigned seq = 1;
  logic [95:0] mq[$];
  logic prev_flush = 0, prev_flush_push = 0, prev_hold = 0, prev_both = 0;
  logic [95:0] prev_data = '0;

  fetch_exec_queue #(.DEPTH(DEPTH), .IW(32), .AW(32)) uut (
    .clk(clk), .rst(rst), .flush(flush),
    .enq_valid(enq_valid), .enq_ready(enq_ready),
    .enq_instr(enq_instr), .enq_pc(enq_pc), .enq_ppc(enq_ppc),
    .deq_valid(deq_valid), .deq_ready(deq_ready),
    .deq_instr(deq_instr), .deq_pc(deq_pc), .deq_ppc(deq_ppc));

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      misses++;
      $display("FAIL watchdog (all requirements) cycles=%0d expected below 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, misses);
      $finish;
    end
  end

  task automatic check96(string tag, logic [95:0] act, logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic ev, logic dr, logic fl);
    logic exp_ready, exp_valid, ef, df;
    @(negedge clk);
    enq_valid = ev; deq_ready = dr; flush = fl;
    enq_instr = 32'hC000_0000 | seq;
    enq_pc    = seq << 2;
    enq_ppc   = (seq << 2) ^ 32'h0000_0010;
    seq++;
    #1;
    exp_ready = (mq.size() != DEPTH);
    exp_valid = (mq.size() != 0);
    if (prev_flush_push) check96("R6 deq_valid after flush+push", 96'(deq_valid), 96'(0));
    else if (prev_flush) check96("R5 empty after flush", 96'({deq_valid, enq_ready}), 96'(2'b01));
    check96("R3 enq_ready", 96'(enq_ready), 96'(exp_ready));
    check96("R4 deq_valid", 96'(deq_valid), 96'(exp_valid));
    if (exp_valid) begin
      if (prev_hold) check96("R8 stalled entry held", {deq_instr, deq_pc, deq_ppc}, prev_data);
      if (prev_both) check96("R7 overlap head", {deq_instr, deq_pc, deq_ppc}, mq[0]);
      else check96("R1 head fields", {deq_instr, deq_pc, deq_ppc}, mq[0]);
    end
    ef = ev && exp_ready;
    df = dr && exp_valid;
    prev_flush = fl;
    prev_flush_push = fl && ef;
    prev_hold = exp_valid && !dr && !fl;
    prev_both = ef && df && !fl;
    prev_data = {deq_instr, deq_pc, deq_ppc};
    @(posedge clk);
    if (fl) mq.delete();
    else begin
      if (df) void'(mq.pop_front());
      if (ef) mq.push_back({enq_instr, enq_pc, enq_ppc});
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; enq_valid = 1; deq_ready = 0; flush = 0;
    @(posedge clk);
    mq.delete();
    prev_flush = 0; prev_flush_push = 0; prev_hold = 0; prev_both = 0;
    @(negedge clk);
    rst = 0; enq_valid = 0;
    #1;
    check96("R2 reset state", 96'({deq_valid, enq_ready}), 96'(2'b01));
  endtask

  initial begin
    repeat (2) @(posedge clk);
    do_reset();
    for (int i = 0; i < NV; i++) step(VEC[i][2], VEC[i][1], VEC[i][0]);
    for (int i = 0; i < 2000; i++) step(($urandom % 4) != 0, ($urandom % 3) != 0, ($urandom % 9) == 0);
    // R3: full queue, push offered with simultaneous pop must be refused
    step(1, 0, 0); step(1, 0, 0); step(1, 1, 0); step(0, 0, 0);
    check96("R3 count after refused push", 96'(mq.size()), 96'(1));
    // R6: flush with push into empty queue
    step(0, 1, 1); step(1, 0, 1); step(0, 0, 0); step(1, 0, 0); step(0, 1, 0);
    // R5: flush with pop on full queue
    step(1, 0, 0); step(1, 0, 0); step(0, 1, 1); step(0, 0, 0);
    // R7: streaming, one per cycle
    step(1, 0, 0);
    for (int i = 0; i < 20; i++) step(1, 1, 0);
    // R8: stall holds
    step(0, 0, 0); step(0, 0, 0); step(0, 1, 0); step(0, 1, 0);
    // R2: reset in mid-traffic
    step(1, 0, 0); step(1, 0, 0);
    do_reset();
    step(1, 1, 0); step(0, 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, misses);
    $finish;
  end
endmodule